// File: doc/BRIEF.md
# Load/Store Address and Data Formatter

This block sits in the data-memory access unit of a byte-addressed processor with 32-bit addresses. Each request names a base pointer value, a pointer mode, an access size and a displacement. The displacement is either a small unsigned constant or a full register value. The block returns the effective byte address for the access. It also returns the pointer value to be written back and a flag that says whether the write-back is wanted.

The displacement counts elements, not bytes, so it is scaled by the access size. Seven pointer modes are supported:

- direct use of the pointer;
- an offset added or subtracted without changing the pointer;
- pre-modification, where the modified pointer is used and kept;
- post-modification, where the old pointer is used and the modified one is kept.

On loads, the memory returns eight bytes. Lane 0 holds the byte at the effective address and higher lanes hold the following addresses. The block assembles these bytes little-endian into a destination register, or into a register pair for a doubleword. Byte and halfword loads are sign-extended or zero-extended as requested.

Address results appear one clock after the request. Load formatting uses the size and signedness captured with that request and follows the memory data combinationally while the response is valid.

Top module: `lsfmt_top`

## Requirements
- R1: After reset `respValid` and `wbValid` are 0 and `effAddr` and `wbPtr` are 0.
- R2: `respValid` is 1 in the cycle after a cycle with `reqValid` = 1, and 0 after a cycle with `reqValid` = 0. `effAddr` and `wbPtr` change only on a request.
- R3: The displacement is `dispReg` when `dispIsReg` = 1, otherwise `dispConst` zero-extended. It is scaled by shifting left by `size`, where `size` encodes 0 = byte, 1 = halfword, 2 = word and 3 = doubleword.
- R4: Mode 0 (plain) gives `effAddr` = base, `wbValid` = 0 and `wbPtr` = base.
- R5: Modes 1 (plus offset) and 2 (minus offset) give `effAddr` = base ± scaled displacement, with `wbValid` = 0 and `wbPtr` = base.
- R6: Modes 3 (pre-increment) and 4 (pre-decrement) give `effAddr` = `wbPtr` = base ± scaled displacement, with `wbValid` = 1.
- R7: Modes 5 (post-increment) and 6 (post-decrement) give `effAddr` = base and `wbPtr` = base ± scaled displacement, with `wbValid` = 1.
- R8: All address arithmetic wraps modulo 2^32.
- R9: Load data is little-endian from `memData` lane 0 (bits 7:0) upward.
  - A byte takes lane 0 and a halfword takes lanes 1:0.
  - A word takes lanes 3:0 into `ldLo`.
  - A doubleword also puts lanes 7:4 into `ldHi`.
  - `ldHi` is 0 for every other size.
- R10: Byte and halfword loads sign-extend when `ldSigned` = 1 and zero-extend otherwise. `ldSigned` has no effect on word and doubleword loads.
- R11: Mode 7 is reserved and behaves as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| mode | input | 3 | Pointer mode code |
| size | input | 2 | Access size code |
| basePtr | input | 32 | Base pointer register value |
| dispIsReg | input | 1 | Select register displacement |
| dispConst | input | 5 | Unsigned constant displacement |
| dispReg | input | 32 | Register displacement |
| ldSigned | input | 1 | Sign-extend short loads |
| memData | input | 64 | Bytes returned by memory, lane 0 lowest address |
| respValid | output | 1 | Result valid |
| effAddr | output | 32 | Effective byte address |
| wbValid | output | 1 | Pointer write-back wanted |
| wbPtr | output | 32 | Pointer value for write-back |
| ldLo | output | 32 | Formatted load data, low register |
| ldHi | output | 32 | Formatted load data, high register (doubleword only) |

## Verification
The address sweep covers every mode code, including the reserved one, with every size and both displacement sources. Constants of 0, 1 and 31 are used, along with register values that are large enough to reach the upper bits when scaled.

A zero displacement separates the modes only through `wbValid`. A non-zero displacement separates pre-modify from post-modify and plus from minus. Bases near zero and near the top of the address space show the wrap in both directions.

Load formatting is tried with an ascending byte pattern, which exposes lane order. It is also tried with bytes whose top bit is set, which exposes the sign handling. Both signedness settings are applied to every size.

// File: rtl/lsfmt_pkg.sv
package lsfmt_pkg;
  typedef enum logic [2:0] {
    PM_PLAIN    = 3'd0,
    PM_PLUS     = 3'd1,
    PM_MINUS    = 3'd2,
    PM_PRE_INC  = 3'd3,
    PM_PRE_DEC  = 3'd4,
    PM_POST_INC = 3'd5,
    PM_POST_DEC = 3'd6,
    PM_RSVD     = 3'd7
  } ptrMode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } accSize_e;

  typedef struct packed {
    logic addrUsesMod;  // effective address takes the modified pointer
    logic subtract;     // modify by subtraction
    logic writeBack;    // modified pointer goes back to the register
  } ctrlStrobes_t;
endpackage

// File: rtl/lsfmt_ctrl.sv
module lsfmt_ctrl
  import lsfmt_pkg::*;
(
  input  logic [2:0]   mode,
  output ctrlStrobes_t strobes
);
  ptrMode_e modeE;
  assign modeE = ptrMode_e'(mode);

  always_comb begin
    strobes = '0;
    unique case (modeE)
      PM_PLUS:     strobes = '{addrUsesMod: 1'b1, subtract: 1'b0, writeBack: 1'b0};
      PM_MINUS:    strobes = '{addrUsesMod: 1'b1, subtract: 1'b1, writeBack: 1'b0};
      PM_PRE_INC:  strobes = '{addrUsesMod: 1'b1, subtract: 1'b0, writeBack: 1'b1};
      PM_PRE_DEC:  strobes = '{addrUsesMod: 1'b1, subtract: 1'b1, writeBack: 1'b1};
      PM_POST_INC: strobes = '{addrUsesMod: 1'b0, subtract: 1'b0, writeBack: 1'b1};
      PM_POST_DEC: strobes = '{addrUsesMod: 1'b0, subtract: 1'b1, writeBack: 1'b1};
      default:     strobes = '0;  // plain and reserved (R11)
    endcase
  end

  // R6/R7: a write-back never happens without a mode that modifies the pointer
  always_comb begin
    if (strobes.writeBack)
      p_wb_mode_r6: assert (modeE inside {PM_PRE_INC, PM_PRE_DEC, PM_POST_INC, PM_POST_DEC});
  end
endmodule

// File: rtl/lsfmt_datapath.sv
module lsfmt_datapath
  import lsfmt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CONST_W = 5,
  parameter int LANES   = 8
) (
  input  ctrlStrobes_t         strobes,
  input  logic [1:0]           size,
  input  logic [ADDR_W-1:0]    basePtr,
  input  logic                 dispIsReg,
  input  logic [CONST_W-1:0]   dispConst,
  input  logic [ADDR_W-1:0]    dispReg,
  output logic [ADDR_W-1:0]    addrNext,
  output logic [ADDR_W-1:0]    ptrNext,
  // load formatting, using the size/sign captured with the request
  input  logic [1:0]           ldSizeQ,
  input  logic                 ldSignedQ,
  input  logic [LANES*8-1:0]   memData,
  output logic [31:0]          ldLo,
  output logic [31:0]          ldHi
);
  localparam int PAD_W = ADDR_W - CONST_W;

  logic [ADDR_W-1:0] dispRaw, dispScaled, modPtr;
  logic [7:0]        lane [LANES];

  assign dispRaw    = dispIsReg ? dispReg : {{PAD_W{1'b0}}, dispConst};
  assign dispScaled = dispRaw << size;
  assign modPtr     = strobes.subtract ? (basePtr - dispScaled) : (basePtr + dispScaled);
  assign addrNext   = strobes.addrUsesMod ? modPtr : basePtr;
  assign ptrNext    = strobes.writeBack ? modPtr : basePtr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = memData[g*8 +: 8];
  end

  always_comb begin
    ldHi = '0;
    unique case (accSize_e'(ldSizeQ))
      SZ_BYTE: ldLo = {{24{ldSignedQ & lane[0][7]}}, lane[0]};
      SZ_HALF: ldLo = {{16{ldSignedQ & lane[1][7]}}, lane[1], lane[0]};
      SZ_WORD: ldLo = {lane[3], lane[2], lane[1], lane[0]};
      default: begin
        ldLo = {lane[3], lane[2], lane[1], lane[0]};
        ldHi = {lane[7], lane[6], lane[5], lane[4]};
      end
    endcase
  end
endmodule

// File: rtl/lsfmt_top.sv
module lsfmt_top
  import lsfmt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CONST_W = 5,
  parameter int LANES   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         mode,
  input  logic [1:0]         size,
  input  logic [ADDR_W-1:0]  basePtr,
  input  logic               dispIsReg,
  input  logic [CONST_W-1:0] dispConst,
  input  logic [ADDR_W-1:0]  dispReg,
  input  logic               ldSigned,
  input  logic [LANES*8-1:0] memData,
  output logic               respValid,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               wbValid,
  output logic [ADDR_W-1:0]  wbPtr,
  output logic [31:0]        ldLo,
  output logic [31:0]        ldHi
);
  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] addrNext, ptrNext;
  logic [1:0]        sizeQ;
  logic              signedQ;

  lsfmt_ctrl u_ctrl (.mode(mode), .strobes(strobes));

  lsfmt_datapath #(.ADDR_W(ADDR_W), .CONST_W(CONST_W), .LANES(LANES)) u_dp (
    .strobes(strobes), .size(size), .basePtr(basePtr),
    .dispIsReg(dispIsReg), .dispConst(dispConst), .dispReg(dispReg),
    .addrNext(addrNext), .ptrNext(ptrNext),
    .ldSizeQ(sizeQ), .ldSignedQ(signedQ), .memData(memData),
    .ldLo(ldLo), .ldHi(ldHi)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      wbValid   <= 1'b0;
      effAddr   <= '0;
      wbPtr     <= '0;
      sizeQ     <= '0;
      signedQ   <= 1'b0;
    end else begin
      respValid <= reqValid;
      wbValid   <= reqValid & strobes.writeBack;
      if (reqValid) begin
        effAddr <= addrNext;
        wbPtr   <= ptrNext;
        sizeQ   <= size;
        signedQ <= ldSigned;
      end
    end
  end

  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && !wbValid && $stable(effAddr) && $stable(wbPtr)));
  p_ptr_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !wbValid) |-> (wbPtr == $past(basePtr)));
  p_post_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (mode == PM_POST_INC || mode == PM_POST_DEC)) |=> (effAddr == $past(basePtr)));
  p_ldhi_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && sizeQ != SZ_DBL) |-> (ldHi == '0));
endmodule

// File: tb/lsfmt_top_tb_top.sv
module lsfmt_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [31:0] basePtr = '0;
  logic        dispIsReg = 1'b0;
  logic [4:0]  dispConst = '0;
  logic [31:0] dispReg = '0;
  logic        ldSigned = 1'b0;
  logic [63:0] memData = '0;
  logic        respValid, wbValid;
  logic [31:0] effAddr, wbPtr, ldLo, ldHi;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  lsfmt_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .size(size),
    .basePtr(basePtr), .dispIsReg(dispIsReg), .dispConst(dispConst), .dispReg(dispReg),
    .ldSigned(ldSigned), .memData(memData), .respValid(respValid), .effAddr(effAddr),
    .wbValid(wbValid), .wbPtr(wbPtr), .ldLo(ldLo), .ldHi(ldHi)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request: drive at negedge, result registered at the next posedge, check at the following negedge
  task automatic addrCase(int m, int sz, logic useReg, logic [4:0] k, logic [31:0] r, logic [31:0] b);
    logic [31:0] disp, sc, modv, expA, expP;
    logic expWb;
    @(negedge clk);
    reqValid = 1'b1; mode = 3'(m); size = 2'(sz); basePtr = b;
    dispIsReg = useReg; dispConst = k; dispReg = r;
    disp = useReg ? r : {27'd0, k};           // R3
    sc   = disp << sz;
    modv = (m == 2 || m == 4 || m == 6) ? b - sc : b + sc;  // R8 wraps in 32 bits
    case (m)
      1, 2: begin expA = modv; expP = b;    expWb = 1'b0; end   // R5
      3, 4: begin expA = modv; expP = modv; expWb = 1'b1; end   // R6
      5, 6: begin expA = b;    expP = modv; expWb = 1'b1; end   // R7
      default: begin expA = b; expP = b;    expWb = 1'b0; end   // R4, R11
    endcase
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 respValid", 64'(respValid), 64'd1);
    check("R3/R4-R8 effAddr", 64'(effAddr), 64'(expA));
    check("R4-R7 wbPtr", 64'(wbPtr), 64'(expP));
    check("R4-R7 wbValid", 64'(wbValid), 64'(expWb));
  endtask

  task automatic loadCase(int sz, logic sgn, logic [63:0] d);
    logic [31:0] eLo, eHi;
    @(negedge clk);
    reqValid = 1'b1; mode = 3'd0; size = 2'(sz); ldSigned = sgn; basePtr = 32'h4; dispConst = '0; dispIsReg = 1'b0;
    @(negedge clk);
    reqValid = 1'b0; ldSigned = ~sgn; memData = d;  // later ldSigned must not matter
    eHi = '0;
    case (sz)
      0: eLo = sgn ? {{24{d[7]}}, d[7:0]}   : {24'd0, d[7:0]};   // R10
      1: eLo = sgn ? {{16{d[15]}}, d[15:0]} : {16'd0, d[15:0]};  // R10
      2: eLo = d[31:0];
      default: begin eLo = d[31:0]; eHi = d[63:32]; end
    endcase
    #1;
    check("R9/R10 ldLo", 64'(ldLo), 64'(eLo));
    check("R9 ldHi", 64'(ldHi), 64'(eHi));
  endtask

  initial begin
    logic [31:0] bases [4] = '{32'h0000_0000, 32'h0000_1000, 32'hFFFF_FFF0, 32'h0000_0010};
    logic [4:0]  ks [3]    = '{5'd0, 5'd1, 5'd31};
    logic [31:0] rs [2]    = '{32'h0000_0003, 32'h4000_0001};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 respValid", 64'(respValid), 64'd0);
    check("R1 wbValid", 64'(wbValid), 64'd0);
    check("R1 effAddr", 64'(effAddr), 64'd0);
    check("R1 wbPtr", 64'(wbPtr), 64'd0);
    rstN = 1'b1;
    for (int m = 0; m < 8; m++)
      for (int sz = 0; sz < 4; sz++)
        for (int bi = 0; bi < 4; bi++) begin
          for (int ki = 0; ki < 3; ki++) addrCase(m, sz, 1'b0, ks[ki], 32'hDEAD_BEEF, bases[bi]);
          for (int ri = 0; ri < 2; ri++) addrCase(m, sz, 1'b1, 5'd7, rs[ri], bases[bi]);
        end
    // R2: idle cycle holds outputs
    @(negedge clk);
    begin
      logic [31:0] a0, p0;
      a0 = effAddr; p0 = wbPtr;
      basePtr = 32'h1234_5678; mode = 3'd3;
      @(negedge clk);
      check("R2 idle respValid", 64'(respValid), 64'd0);
      check("R2 idle wbValid", 64'(wbValid), 64'd0);
      check("R2 idle effAddr", 64'(effAddr), 64'(a0));
      check("R2 idle wbPtr", 64'(wbPtr), 64'(p0));
    end
    for (int sz = 0; sz < 4; sz++)
      for (int s = 0; s < 2; s++) begin
        loadCase(sz, 1'(s), 64'h0807_0605_0403_0201);
        loadCase(sz, 1'(s), 64'hF0E0_D0C0_B0A0_9080);
        loadCase(sz, 1'(s), 64'h7F00_FF7F_0080_80FF);
      end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule